// File: doc/BRIEF.md
# Monochrome Frame Store Pixel Scanout

This block holds a one-bit-per-pixel screen image in a single-port store of 32-bit words and streams it out as a serial pixel sequence for a raster display, one pixel per clock. Each word holds 32 horizontally adjacent pixels, shifted out most significant bit first, so a pixel at column x and row y lives in word (y*W + x)/32 at bit 31 - ((y*W + x) mod 32). The stream carries a valid strobe, a strobe on the first pixel of every line and a strobe on the first pixel of every frame.

Software changes the image through a write port that shares the store's only access port with scanout. The next word is read one clock before the shift register runs dry, so the stream has no gaps. A CPU write that lands on a read cycle is held off for one clock by a stall output. Screen width (a multiple of 32) and height are parameters; the default is 128 by 128, which gives 512 words.

Top module: `fb_scanout`

## Requirements
- R1: While reset is high, and in the first cycle after the first clock edge that sees reset low, pix_valid, line_start and frame_start are all 0.
- R2: pix_valid rises after the second clock edge that sees reset low, and in that cycle frame_start is 1 and the pixel shown is (0,0).
- R3: The pixel shown in the k-th valid cycle of a frame (k = y*W + x) is bit 31 - (k mod 32) of store word k/32. So bit 31 of word 0 is the upper-left pixel and bit 0 of word 0 is the 32nd pixel of the top row.
- R4: Once pix_valid is 1 it stays 1 on every cycle until the next reset, across word, line and frame boundaries.
- R5: line_start is 1 exactly on valid cycles with x = 0, and so comes every W cycles. frame_start is 1 exactly on the cycle showing pixel (0,0).
- R6: After the last pixel of the last word, the next cycle shows pixel (0,0) from word 0 with frame_start set.
- R7: cpu_wr_stall is 1 exactly when cpu_wr_en is 1 in a cycle in which the store is being read. Read cycles are the first cycle after reset and every valid cycle whose pixel index mod 32 is 30. A write with cpu_wr_stall at 0 updates the word at the next clock edge.
- R8: A write to a word that lands before that word is read shows in the current frame. A write that lands after the read shows from the next frame on, and this includes a stalled write to the word being read in the stall cycle. The store keeps its contents through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr_en | input | 1 | CPU write request; held until accepted |
| cpu_wr_addr | input | 9 | Word address to write (log2 of W*H/32 bits) |
| cpu_wr_data | input | 32 | Word of 32 pixels, MSB leftmost |
| cpu_wr_stall | output | 1 | Write not taken this cycle; keep it asserted |
| pix_data | output | 1 | Current pixel |
| pix_valid | output | 1 | A pixel is shown this cycle |
| line_start | output | 1 | First pixel of a line |
| frame_start | output | 1 | First pixel of a frame |

## Verification
The bench goes after the points where the word pipeline turns over. A bit order reversed inside a word, or a word address off by one, would show up as miscompared words. A prefetch issued a cycle late would put a gap in pix_valid or show a stale word. A wrap that misses word 0 would corrupt the first word of the next frame. The bench also drives CPU writes on the exact read cycle and on the cycle just before a word's read. If arbitration were wrong, a stall would be dropped or made up, or a write would show up in the wrong frame. It also checks that a reset in mid-frame restarts the stream at (0,0) with the image kept.

// File: rtl/fb_scanout_pkg.sv
package fb_scanout_pkg;

    localparam int unsigned PIX_PER_WORD = 32;
    localparam int unsigned BIT_W        = $clog2(PIX_PER_WORD);

    typedef enum logic [1:0] {
        PH_PRIME = 2'd0,
        PH_LOAD  = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } port_op_t;

    function automatic int unsigned words_for(int unsigned w, int unsigned h);
        return (w * h) / PIX_PER_WORD;
    endfunction

    function automatic int unsigned word_index(int unsigned x, int unsigned y,
                                               int unsigned width);
        return (y * width + x) / PIX_PER_WORD;
    endfunction

endpackage

// File: rtl/fb_store.sv
module fb_store #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned DW    = 32,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[addr] <= wdata;
        end else if (rd_en) begin
            rdata <= cells[addr];
        end
    end

endmodule

// File: rtl/fb_raster_ctr.sv
module fb_raster_ctr #(
    parameter int unsigned SCR_W = 128,
    parameter int unsigned SCR_H = 128,
    localparam int unsigned XW   = $clog2(SCR_W),
    localparam int unsigned YW   = $clog2(SCR_H)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y
);

    logic x_last;
    logic y_last;

    assign x_last = (x == XW'(SCR_W - 1));
    assign y_last = (y == YW'(SCR_H - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            x <= '0;
            y <= '0;
        end else if (adv) begin
            if (x_last) begin
                x <= '0;
                y <= y_last ? '0 : y + 1'b1;
            end else begin
                x <= x + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fb_scanout.sv
module fb_scanout
    import fb_scanout_pkg::*;
#(
    parameter int unsigned SCR_W  = 128,
    parameter int unsigned SCR_H  = 128,
    localparam int unsigned NWORDS = words_for(SCR_W, SCR_H),
    localparam int unsigned AW     = $clog2(NWORDS),
    localparam int unsigned XW     = $clog2(SCR_W),
    localparam int unsigned YW     = $clog2(SCR_H)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cpu_wr_en,
    input  logic [AW-1:0]           cpu_wr_addr,
    input  logic [PIX_PER_WORD-1:0] cpu_wr_data,
    output logic                    cpu_wr_stall,
    output logic                    pix_data,
    output logic                    pix_valid,
    output logic                    line_start,
    output logic                    frame_start
);

    phase_e                  phase;
    logic [BIT_W-1:0]        bit_cnt;
    logic [PIX_PER_WORD-1:0] sreg;
    logic [PIX_PER_WORD-1:0] rd_word;
    logic [AW-1:0]           fetch_ptr;
    logic [AW-1:0]           mem_addr;
    logic [XW-1:0]           x;
    logic [YW-1:0]           y;
    logic                    running;
    logic                    fetch_now;
    logic                    load_now;
    port_op_t                op;

    assign running   = (phase == PH_RUN);
    // read one pixel ahead of the shift register running dry
    assign fetch_now = (phase == PH_PRIME) ||
                       (running && bit_cnt == BIT_W'(PIX_PER_WORD - 2));
    assign load_now  = (phase == PH_LOAD) ||
                       (running && bit_cnt == BIT_W'(PIX_PER_WORD - 1));

    always_comb begin
        op.rd = fetch_now;
        op.wr = cpu_wr_en && !fetch_now;
    end

    assign mem_addr     = op.rd ? fetch_ptr : cpu_wr_addr;
    assign cpu_wr_stall = cpu_wr_en && op.rd;

    fb_store #(
        .DEPTH (NWORDS),
        .DW    (PIX_PER_WORD)
    ) store_i (
        .clk   (clk),
        .rd_en (op.rd),
        .wr_en (op.wr),
        .addr  (mem_addr),
        .wdata (cpu_wr_data),
        .rdata (rd_word)
    );

    fb_raster_ctr #(
        .SCR_W (SCR_W),
        .SCR_H (SCR_H)
    ) raster_i (
        .clk (clk),
        .rst (rst),
        .adv (running),
        .x   (x),
        .y   (y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_PRIME;
            bit_cnt   <= '0;
            sreg      <= '0;
            fetch_ptr <= '0;
        end else begin
            unique case (phase)
                PH_PRIME: phase <= PH_LOAD;
                PH_LOAD:  phase <= PH_RUN;
                default:  phase <= PH_RUN;
            endcase
            if (fetch_now) begin
                fetch_ptr <= (fetch_ptr == AW'(NWORDS - 1)) ? '0 : fetch_ptr + 1'b1;
            end
            if (load_now) begin
                sreg    <= rd_word;
                bit_cnt <= '0;
            end else if (running) begin
                sreg    <= {sreg[PIX_PER_WORD-2:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    assign pix_data    = sreg[PIX_PER_WORD-1];
    assign pix_valid   = running;
    assign line_start  = running && (x == '0);
    assign frame_start = line_start && (y == '0);

endmodule

// File: rtl/fb_scanout_chk.sv
module fb_scanout_chk
    import fb_scanout_pkg::*;
#(
    parameter int unsigned SCR_W  = 128,
    parameter int unsigned SCR_H  = 128,
    localparam int unsigned NWORDS = words_for(SCR_W, SCR_H),
    localparam int unsigned AW     = $clog2(NWORDS),
    localparam int unsigned XW     = $clog2(SCR_W),
    localparam int unsigned YW     = $clog2(SCR_H),
    localparam int unsigned CW     = $clog2(SCR_W) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          pix_valid,
    input logic          line_start,
    input logic          frame_start,
    input logic          cpu_wr_en,
    input logic          cpu_wr_stall,
    input logic          fetch_now,
    input logic [AW-1:0] fetch_ptr,
    input logic [XW-1:0] x,
    input logic [YW-1:0] y
);

    logic [CW-1:0] gap_cnt;
    logic          seen_line;
    logic [AW-1:0] exp_next;
    int unsigned   cur_word;

    always_comb begin
        cur_word = word_index(int'(x), int'(y), SCR_W);
        exp_next = (cur_word == NWORDS - 1) ? '0 : AW'(cur_word + 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt   <= '0;
            seen_line <= 1'b0;
        end else if (line_start) begin
            gap_cnt   <= '0;
            seen_line <= 1'b1;
        end else begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !pix_valid);

    // R2
    first_pixel_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pix_valid) |-> frame_start);

    // R4
    no_gap_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> pix_valid);

    // R5
    frame_on_line_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (line_start && pix_valid));

    // R5
    line_period_chk: assert property (@(posedge clk) disable iff (rst)
        (line_start && seen_line) |-> (gap_cnt == CW'(SCR_W - 1)));

    // R6
    next_word_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_now && pix_valid) |-> (fetch_ptr == exp_next));

    // R2
    prime_word_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_now && !pix_valid) |-> (fetch_ptr == '0));

    // R7
    stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_wr_stall |-> (cpu_wr_en && fetch_now));

endmodule

bind fb_scanout fb_scanout_chk #(
    .SCR_W (SCR_W),
    .SCR_H (SCR_H)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .pix_valid    (pix_valid),
    .line_start   (line_start),
    .frame_start  (frame_start),
    .cpu_wr_en    (cpu_wr_en),
    .cpu_wr_stall (cpu_wr_stall),
    .fetch_now    (fetch_now),
    .fetch_ptr    (fetch_ptr),
    .x            (x),
    .y            (y)
);

// File: tb/fb_scanout_tb_top.sv
module fb_scanout_tb_top;

    localparam int W      = 128;
    localparam int H      = 128;
    localparam int NW     = W * H / 32;
    localparam int NPIX   = W * H;
    localparam int AW     = $clog2(NW);
    localparam int NVEC   = 16;
    localparam int WD_MAX = 150000;

    // {word address, word data}
    localparam logic [40:0] VEC [NVEC] = '{
        {9'd0,   32'h8000_0001}, {9'd3,   32'h0000_0001},
        {9'd4,   32'h8000_0000}, {9'd511, 32'hFFFF_FFFF},
        {9'd510, 32'h0000_0000}, {9'd2,   32'h1234_5678},
        {9'd1,   32'hA5A5_5A5A}, {9'd127, 32'hC000_0003},
        {9'd128, 32'h0F0F_F0F0}, {9'd255, 32'h7FFF_FFFE},
        {9'd256, 32'h0000_8000}, {9'd300, 32'hDEAD_BEEF},
        {9'd383, 32'h0000_0001}, {9'd384, 32'h8000_0000},
        {9'd5,   32'hF0F0_0F0F}, {9'd509, 32'h5555_AAAA}
    };

    localparam logic [31:0] NEW_A = 32'hCAFE_F00D;
    localparam logic [31:0] NEW_B = 32'h0BAD_C0DE;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_wr_en = 1'b0;
    logic [AW-1:0] cpu_wr_addr = '0;
    logic [31:0]   cpu_wr_data = '0;
    logic          cpu_wr_stall;
    logic          pix_data;
    logic          pix_valid;
    logic          line_start;
    logic          frame_start;

    int          n_chk  = 0;
    int          n_fail = 0;
    int          cycles = 0;
    logic [31:0] img [NW];
    logic [31:0] expw [NW];

    always #10 clk = ~clk;

    fb_scanout dut_i (
        .clk          (clk),
        .rst          (rst),
        .cpu_wr_en    (cpu_wr_en),
        .cpu_wr_addr  (cpu_wr_addr),
        .cpu_wr_data  (cpu_wr_data),
        .cpu_wr_stall (cpu_wr_stall),
        .pix_data     (pix_data),
        .pix_valid    (pix_valid),
        .line_start   (line_start),
        .frame_start  (frame_start)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        cpu_wr_en   = 1'b1;
        cpu_wr_addr = AW'(addr);
        cpu_wr_data = data;
        #1;
        while (cpu_wr_stall) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cpu_wr_en = 1'b0;
    endtask

    task automatic quiet_check(input string req);
        chk(!pix_valid && !line_start && !frame_start, req,
            {29'd0, pix_valid, line_start, frame_start}, 32'd0);
    endtask

    // called at the negedge of the cycle that should show pixel (0,0)
    task automatic check_frame(input string tag);
        logic [31:0] acc = '0;
        int          bad = 0;
        logic [2:0]  got_f;
        logic [2:0]  exp_f;
        for (int k = 0; k < NPIX; k++) begin
            got_f = {pix_valid, line_start, frame_start};
            exp_f = {1'b1, (k % W) == 0, k == 0};
            if (got_f != exp_f) begin
                if (bad == 0)
                    $display("  %s strobe mismatch at pixel %0d: %b vs %b", tag, k, got_f, exp_f);
                bad++;
            end
            acc = {acc[30:0], pix_data};
            if (k % 32 == 31)
                chk(acc == expw[k / 32], $sformatf("R3 %s word %0d", tag, k / 32),
                    acc, expw[k / 32]);
            if (k != NPIX - 1) @(negedge clk);
        end
        chk(bad == 0, $sformatf("R4/R5 %s strobes", tag), 32'(bad), 32'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WD_MAX) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected<%0d", cycles, WD_MAX);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        for (int w = 0; w < NW; w++) img[w] = (32'(w) * 32'h9E37_79B1) ^ 32'h3C3C_0000;

        // R1: outputs quiet while in reset
        repeat (3) begin
            @(negedge clk);
            quiet_check("R1 in reset");
        end

        // release reset and request a write during the priming read
        @(negedge clk);
        rst         = 1'b0;
        cpu_wr_en   = 1'b1;
        cpu_wr_addr = '0;
        cpu_wr_data = img[0];
        #1;
        chk(cpu_wr_stall == 1'b1, "R7 stall on priming read", 32'(cpu_wr_stall), 32'd1);
        @(negedge clk);
        #1;
        quiet_check("R1 first cycle after reset");
        chk(cpu_wr_stall == 1'b0, "R7 no stall after priming", 32'(cpu_wr_stall), 32'd0);
        @(negedge clk);
        cpu_wr_en = 1'b0;
        chk(pix_valid && frame_start && line_start, "R2 first pixel strobes",
            {29'd0, pix_valid, line_start, frame_start}, 32'h7);

        // load image, then apply the vector table over it
        for (int w = 0; w < NW; w++) wr(w, img[w]);
        for (int v = 0; v < NVEC; v++) begin
            wr(int'(VEC[v][40:32]), VEC[v][31:0]);
            img[VEC[v][40:32]] = VEC[v][31:0];
        end

        // steady frame with the full image (R3, R4, R5)
        do @(negedge clk); while (!frame_start);
        expw = img;
        check_frame("steady");

        // R6: the next cycle wraps to word 0; R8: writes in mid-frame
        img[2] = NEW_A;
        expw   = img;
        @(negedge clk);
        fork
            check_frame("R6 wrap / R8 midframe");
            begin
                repeat (5) @(negedge clk);
                cpu_wr_en   = 1'b1;
                cpu_wr_addr = AW'(2);
                cpu_wr_data = NEW_A;
                #1;
                chk(cpu_wr_stall == 1'b0, "R7 no stall off read cycle", 32'(cpu_wr_stall), 32'd0);
                @(negedge clk);
                cpu_wr_en = 1'b0;
                repeat (24) @(negedge clk);
                cpu_wr_en   = 1'b1;
                cpu_wr_addr = AW'(1);
                cpu_wr_data = NEW_B;
                #1;
                chk(cpu_wr_stall == 1'b1, "R7 stall on prefetch cycle", 32'(cpu_wr_stall), 32'd1);
                @(negedge clk);
                #1;
                chk(cpu_wr_stall == 1'b0, "R7 stall lasts one cycle", 32'(cpu_wr_stall), 32'd0);
                @(negedge clk);
                cpu_wr_en = 1'b0;
            end
        join

        // R8: stalled write to word 1 appears only in this frame
        img[1] = NEW_B;
        expw   = img;
        @(negedge clk);
        check_frame("R8 next frame");

        // reset in mid-frame: restart at (0,0), image kept
        repeat (100) @(negedge clk);
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            quiet_check("R1 mid-frame reset");
        end
        rst = 1'b0;
        @(negedge clk);
        quiet_check("R1 after mid-frame reset");
        @(negedge clk);
        check_frame("R2 restart R8 kept");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule